// File: doc/BRIEF.md
# Register Access Lock Gate

This block guards a small bank of peripheral registers behind a key-based lock. Software reaches the bank through a simple single-cycle register bus. Each access carries a select, a write flag, a word address, write data and a privilege flag. Out of reset the gate is locked. Writing the 32-bit key `0x0ACCE550` to the lock register opens it. Writing any other value to the lock register closes it again. The lock is held by a two-state machine with the states LK_LOCKED and LK_OPEN:

- The KEY_MATCH transition moves LK_LOCKED to LK_OPEN.
- The KEY_MISS transition moves LK_OPEN to LK_LOCKED.
- A key write in LK_OPEN keeps the gate in LK_OPEN.
- A wrong value written in LK_LOCKED keeps the gate in LK_LOCKED.

A separate protection-mode bit sits on top of the lock. When it is set, every access must be privileged. The protection bit itself can only be touched by privileged accesses, whatever its value.

A rejected access is either a privilege violation or a gated access while locked. It changes nothing, returns zero read data and raises a one-cycle error. Read data and the error flag are registered, so they appear in the cycle after the access is sampled on a rising edge.

Top module: `reg_lock_gate`

## Requirements
- R1: After reset the gate is locked, the status register at offset 0x20 reads 0x00000001, the protection bit is 0, and every array register holds 0.
- R2: A write of exactly 0x0ACCE550 to the lock register at offset 0x1C opens the gate, so the status register reads 0. Writing the key again while open keeps the gate open.
- R3: A write of any other value to offset 0x1C locks the gate, so the status register reads 1. This holds from either state, including for values that differ from the key in one bit.
- R4: While locked, an access to an array register or to the protection register is rejected. It raises `bus_err`, returns read data 0 and changes no state.
- R5: While the protection bit is 1, any unprivileged access to any offset is rejected. It raises `bus_err`, returns 0 and changes no state, and this includes lock writes. With the protection bit at 0, unprivileged accesses to the array are accepted.
- R6: The protection register at offset 0x18 keeps bit 0 of a privileged write and reads back with bits [31:1] as 0. Any unprivileged access to it is rejected, even while protection mode is off.
- R7: The identification register at offset 0xFE0 reads 0x00000090 whether the gate is locked or open. Writes to it have no effect.
- R8: The lock register reads 0. The status register holds the lock state in bit 0 with bits [31:1] zero, and writes to it are ignored without an error.
- R9: An access to an unmapped offset returns 0, raises no error and changes no state. `bus_err` and `bus_rdata` are 0 in any cycle that does not follow an access.
- R10: When the gate is open, the NREG array registers are read and written at offsets 0x00 + 4*i. Address bits [1:0] are ignored.
- R11: `bus_rdata` and `bus_err` are registered and reflect the access sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | 1 = privileged access |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the access |
| bus_err | output | 1 | Rejection pulse, one cycle after the access |

## Verification
The assertions assume one access per selected cycle and inputs that are stable around the rising edge. They also assume that NREG stays at six or below, so the array never overlaps the protection word. Writes to the protection register are assumed to carry zeros in bits [31:1]. The bench drives every access on a falling edge and leaves an idle cycle between accesses, which lets each registered response be checked alone. It only ever writes 0 or 1 into the protection register.

// File: rtl/rlg_pkg.sv
package rlg_pkg;
    localparam int DW = 32;
    localparam int AW = 12;

    localparam logic [DW-1:0] UNLOCK_KEY = 32'h0ACC_E550;
    localparam logic [7:0]    ID_BYTE    = 8'h90;

    // Word indices (byte offset >> 2) of the fixed registers
    localparam logic [AW-3:0] W_PROT = 10'h006;
    localparam logic [AW-3:0] W_LOCK = 10'h007;
    localparam logic [AW-3:0] W_STAT = 10'h008;
    localparam logic [AW-3:0] W_ID   = 10'h3F8;

    typedef enum logic [2:0] {
        RG_ARRAY,
        RG_PROT,
        RG_LOCK,
        RG_STAT,
        RG_ID,
        RG_NONE
    } region_e;

    typedef enum logic [0:0] {
        LK_LOCKED = 1'b0,
        LK_OPEN   = 1'b1
    } lock_state_e;
endpackage

// File: rtl/rlg_decode.sv
module rlg_decode
    import rlg_pkg::*;
#(
    parameter int NREG = 4,
    localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic [AW-1:0]   addr,
    output region_e         region,
    output logic [IDXW-1:0] idx
);
    localparam logic [AW-3:0] NREG_W = (AW-2)'(NREG);

    logic [AW-3:0] word;

    assign word = addr[AW-1:2];
    assign idx  = word[IDXW-1:0];

    always_comb begin
        if (word < NREG_W)        region = RG_ARRAY;
        else if (word == W_PROT)  region = RG_PROT;
        else if (word == W_LOCK)  region = RG_LOCK;
        else if (word == W_STAT)  region = RG_STAT;
        else if (word == W_ID)    region = RG_ID;
        else                      region = RG_NONE;
    end
endmodule

// File: rtl/rlg_lock_fsm.sv
module rlg_lock_fsm
    import rlg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_wr,
    input  logic [DW-1:0] key_data,
    output logic          locked
);
    lock_state_e state_q, state_d;
    logic        key_hit;

    assign key_hit = (key_data == UNLOCK_KEY);

    // Next state: KEY_MATCH opens, KEY_MISS closes
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOCKED: if (key_wr && key_hit)  state_d = LK_OPEN;
            LK_OPEN:   if (key_wr && !key_hit) state_d = LK_LOCKED;
            default:   state_d = LK_LOCKED;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_LOCKED;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            LK_LOCKED: locked = 1'b1;
            LK_OPEN:   locked = 1'b0;
            default:   locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/rlg_regfile.sv
module rlg_regfile
    import rlg_pkg::*;
#(
    parameter int NREG = 4,
    localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [IDXW-1:0] idx,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata
);
    logic [DW-1:0] mem [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             mem[g] <= '0;
            else if (we && (idx == IDXW'(g)))       mem[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (idx == IDXW'(i)) rdata = mem[i];
        end
    end
endmodule

// File: rtl/reg_lock_gate.sv
module reg_lock_gate
    import rlg_pkg::*;
#(
    parameter int NREG = 4   // at most 6, so the array stays below the protection word
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic          bus_priv,
    input  logic [11:0]   bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          bus_err
);
    localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1;

    region_e         region;
    logic [IDXW-1:0] idx;
    logic            locked;
    logic            prot_q;
    logic [DW-1:0]   arr_rdata;
    logic [DW-1:0]   rd_mux;
    logic            priv_fail, lock_fail, reject, accept;
    logic            arr_we, prot_we, lock_we;
    logic [DW-1:0]   rdata_q;
    logic            err_q;

    rlg_decode #(.NREG(NREG)) u_decode (
        .addr   (bus_addr),
        .region (region),
        .idx    (idx)
    );

    // Access policy: privilege first, then the lock
    always_comb begin
        priv_fail = bus_sel && !bus_priv && (prot_q || region == RG_PROT);
        lock_fail = bus_sel && locked && (region == RG_ARRAY || region == RG_PROT);
        reject    = priv_fail || lock_fail;
        accept    = bus_sel && !reject;
        arr_we    = accept && bus_wr && (region == RG_ARRAY);
        prot_we   = accept && bus_wr && (region == RG_PROT);
        lock_we   = accept && bus_wr && (region == RG_LOCK);
    end

    rlg_lock_fsm u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (lock_we),
        .key_data (bus_wdata),
        .locked   (locked)
    );

    rlg_regfile #(.NREG(NREG)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (arr_we),
        .idx   (idx),
        .wdata (bus_wdata),
        .rdata (arr_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       prot_q <= 1'b0;
        else if (prot_we) prot_q <= bus_wdata[0];
    end

    always_comb begin
        unique case (region)
            RG_ARRAY: rd_mux = arr_rdata;
            RG_PROT:  rd_mux = {{(DW-1){1'b0}}, prot_q};
            RG_STAT:  rd_mux = {{(DW-1){1'b0}}, locked};
            RG_ID:    rd_mux = {{(DW-8){1'b0}}, ID_BYTE};
            default:  rd_mux = '0;
        endcase
    end

    // Registered response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            rdata_q <= (accept && !bus_wr) ? rd_mux : '0;
            err_q   <= reject;
        end
    end

    assign bus_rdata = rdata_q;
    assign bus_err   = err_q;
endmodule

// File: rtl/rlg_checker.sv
module rlg_checker
    import rlg_pkg::*;
#(
    parameter int NREG = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic        bus_priv,
    input logic [11:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        bus_err,
    input logic        locked,
    input logic        prot_q
);
    localparam logic [9:0] NREG_W = 10'(NREG);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (locked && !prot_q));

    // R2
    key_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_priv && bus_addr[11:2] == W_LOCK && bus_wdata == UNLOCK_KEY)
        |=> !locked);

    // R3
    wrong_key_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_priv && bus_addr[11:2] == W_LOCK && bus_wdata != UNLOCK_KEY)
        |=> locked);

    // R4
    locked_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && bus_sel && bus_addr[11:2] < NREG_W) |=> (bus_err && bus_rdata == 32'h0));

    // R5
    unpriv_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_q && bus_sel && !bus_priv) |=> (bus_err && bus_rdata == 32'h0));

    // R6
    prot_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_priv && bus_addr[11:2] == W_PROT) |=> bus_err);

    // R6
    prot_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && bus_priv && bus_addr[11:2] == W_PROT) |=> $stable(prot_q));

    // R7
    id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_priv && bus_addr[11:2] == W_ID)
        |=> (bus_rdata == 32'h90 && !bus_err));

    // R8
    lock_wo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr[11:2] == W_LOCK) |=> (bus_rdata == 32'h0));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> (!bus_err && bus_rdata == 32'h0));
endmodule

bind reg_lock_gate rlg_checker #(.NREG(NREG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_priv  (bus_priv),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .locked    (locked),
    .prot_q    (prot_q)
);

// File: tb/reg_lock_gate_bench.sv
`timescale 1ns/1ps
module reg_lock_gate_bench;
    localparam logic [31:0] KEY = 32'h0ACC_E550;
    localparam logic [11:0] A_PROT = 12'h018, A_LOCK = 12'h01C, A_STAT = 12'h020, A_ID = 12'hFE0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_priv = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    reg_lock_gate #(.NREG(4)) u_reg_lock_gate (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_priv(bus_priv),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access; response sampled on the falling edge after the capturing edge
    task automatic acc(input logic wr, input logic [11:0] addr, input logic [31:0] wd,
                       input logic priv, output logic [31:0] rd, output logic er);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = addr; bus_wdata = wd; bus_priv = priv;
        @(negedge clk);
        rd = bus_rdata; er = bus_err;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; bus_priv = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] addr, input logic priv,
                          input logic [31:0] exp_d, input logic exp_e);
        logic [31:0] d; logic e;
        acc(1'b0, addr, 32'h0, priv, d, e);
        chk({req, " rdata"}, d, exp_d);
        chk({req, " err"}, {31'b0, e}, {31'b0, exp_e});
    endtask

    task automatic wr_chk(input string req, input logic [11:0] addr, input logic [31:0] wd,
                          input logic priv, input logic exp_e);
        logic [31:0] d; logic e;
        acc(1'b1, addr, wd, priv, d, e);
        chk({req, " err"}, {31'b0, e}, {31'b0, exp_e});
    endtask

    task automatic t_reset;
        rd_chk("R1 status after reset", A_STAT, 1'b1, 32'h1, 1'b0);
        rd_chk("R4 locked array read", 12'h000, 1'b1, 32'h0, 1'b1);
        rd_chk("R4 locked prot read", A_PROT, 1'b1, 32'h0, 1'b1);
        rd_chk("R7 id while locked", A_ID, 1'b0, 32'h90, 1'b0);
    endtask

    task automatic t_locked_write;
        wr_chk("R4 locked array write", 12'h004, 32'hDEAD_BEEF, 1'b1, 1'b1);
        wr_chk("R4 locked prot write", A_PROT, 32'h1, 1'b1, 1'b1);
        wr_chk("R3 wrong value while locked", A_LOCK, 32'h0ACC_E551, 1'b1, 1'b0);
        rd_chk("R3 still locked", A_STAT, 1'b1, 32'h1, 1'b0);
    endtask

    task automatic t_unlock;
        wr_chk("R2 key write", A_LOCK, KEY, 1'b1, 1'b0);
        rd_chk("R2 status open", A_STAT, 1'b1, 32'h0, 1'b0);
        wr_chk("R2 key again", A_LOCK, KEY, 1'b1, 1'b0);
        rd_chk("R2 stays open", A_STAT, 1'b1, 32'h0, 1'b0);
        rd_chk("R8 lock reads zero", A_LOCK, 1'b1, 32'h0, 1'b0);
        wr_chk("R8 status write", A_STAT, 32'h1, 1'b1, 1'b0);
        rd_chk("R8 status unchanged", A_STAT, 1'b1, 32'h0, 1'b0);
        rd_chk("R1 array zero", 12'h00C, 1'b1, 32'h0, 1'b0);
        rd_chk("R4 ignored write left zero", 12'h004, 1'b1, 32'h0, 1'b0);
        rd_chk("R1 prot zero", A_PROT, 1'b1, 32'h0, 1'b0);
    endtask

    task automatic t_array;
        for (int i = 0; i < 4; i++)
            wr_chk("R10 array write", 12'(i * 4), 32'h1111_0000 + 32'(i), 1'b0, 1'b0);
        wr_chk("R10 low bits ignored", 12'h00B, 32'hCAFE_0002, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++)
            rd_chk("R10 array read", 12'(i * 4 + 1), 1'b0,
                   (i == 2) ? 32'hCAFE_0002 : 32'h1111_0000 + 32'(i), 1'b0);
    endtask

    task automatic t_protection;
        wr_chk("R6 unpriv prot write", A_PROT, 32'h1, 1'b0, 1'b1);
        rd_chk("R6 prot still 0", A_PROT, 1'b1, 32'h0, 1'b0);
        rd_chk("R6 unpriv prot read", A_PROT, 1'b0, 32'h0, 1'b1);
        wr_chk("R6 priv prot write", A_PROT, 32'h1, 1'b1, 1'b0);
        rd_chk("R6 prot reads 1", A_PROT, 1'b1, 32'h1, 1'b0);
        rd_chk("R5 unpriv array read", 12'h004, 1'b0, 32'h0, 1'b1);
        wr_chk("R5 unpriv array write", 12'h004, 32'h0000_0BAD, 1'b0, 1'b1);
        rd_chk("R5 array untouched", 12'h004, 1'b1, 32'h1111_0001, 1'b0);
        wr_chk("R5 unpriv lock write", A_LOCK, 32'h0, 1'b0, 1'b1);
        rd_chk("R5 still open", A_STAT, 1'b1, 32'h0, 1'b0);
        rd_chk("R5 unpriv id read", A_ID, 1'b0, 32'h0, 1'b1);
        rd_chk("R5 unpriv unmapped", 12'h100, 1'b0, 32'h0, 1'b1);
        wr_chk("R6 clear prot", A_PROT, 32'h0, 1'b1, 1'b0);
        rd_chk("R5 unpriv ok when off", 12'h004, 1'b0, 32'h1111_0001, 1'b0);
    endtask

    task automatic t_unmapped;
        rd_chk("R9 unmapped read", 12'h100, 1'b1, 32'h0, 1'b0);
        wr_chk("R9 unmapped write", 12'h100, 32'hFFFF_FFFF, 1'b1, 1'b0);
        wr_chk("R9 unmapped write 2", 12'h024, 32'h0, 1'b1, 1'b0);
        rd_chk("R9 array unchanged", 12'h000, 1'b1, 32'h1111_0000, 1'b0);
        rd_chk("R9 status unchanged", A_STAT, 1'b1, 32'h0, 1'b0);
        wr_chk("R7 id write", A_ID, 32'h0000_0011, 1'b1, 1'b0);
        rd_chk("R7 id unchanged", A_ID, 1'b1, 32'h90, 1'b0);
    endtask

    task automatic t_relock;
        wr_chk("R3 near key locks", A_LOCK, 32'h0ACC_E540, 1'b1, 1'b0);
        rd_chk("R3 status locked", A_STAT, 1'b1, 32'h1, 1'b0);
        wr_chk("R4 array write locked", 12'h000, 32'h0, 1'b1, 1'b1);
        // R9: the cycle after a rejected access carries no error
        @(negedge clk);
        chk("R9 idle after reject", {31'b0, bus_err}, 32'h0);
        chk("R11 idle rdata", bus_rdata, 32'h0);
        wr_chk("R2 reopen", A_LOCK, KEY, 1'b1, 1'b0);
        rd_chk("R4 array kept", 12'h000, 1'b1, 32'h1111_0000, 1'b0);
        wr_chk("R3 zero locks", A_LOCK, 32'h0, 1'b1, 1'b0);
        rd_chk("R3 locked again", A_STAT, 1'b1, 32'h1, 1'b0);
    endtask

    task automatic t_timing;
        // R11: response appears only after the capturing edge
        wr_chk("R11 unlock", A_LOCK, KEY, 1'b1, 1'b0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'h008; bus_priv = 1'b1;
        #1;
        chk("R11 not yet", bus_rdata, 32'h0);
        @(negedge clk);
        chk("R11 after edge", bus_rdata, 32'hCAFE_0002);
        bus_sel = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 err at reset", {31'b0, bus_err}, 32'h0);
        rst_n = 1'b1;
        t_reset();
        t_locked_write();
        t_unlock();
        t_array();
        t_protection();
        t_unmapped();
        t_relock();
        t_timing();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule